// File: doc/BRIEF.md
# Control-Transfer Classifier and Target Generator

This block belongs to the fetch stage of a pipelined core whose program counter counts words rather than bytes. Each cycle it takes the fetched 32-bit instruction, the current PC and a decoded instruction-type code. It sorts the instruction into one of four control-transfer classes. It also works out two candidate next addresses: the taken target and the fall-through. The three results are registered for the following stage.

Offsets are assembled from the instruction fields with no implied zero in the low bit. Each one is sign-extended and added directly to the word-indexed PC. The fall-through address is therefore PC plus one.

For register-indirect jumps, the block exports the source-register index taken from the instruction. An external register file returns the base value in the same cycle, and the block adds the 12-bit immediate to it. Branch resolution, flushing and instruction memory are handled by other logic.

The block updates only while the pipeline-enable input is high. While it is low, the registered outputs keep their values.

Top module: `xfer_classifier`

## Requirements
- R1: When the type code equals 3, the registered class becomes 3 (conditional branch), whatever the opcode field holds.
- R2: When the type code equals 5, the registered class becomes 1 (direct jump-and-link), whatever the opcode field holds.
- R3: When the type code is neither 3 nor 5, the class becomes 2 (register-indirect jump) if instruction bits 6:0 equal 7'h67, and 0 otherwise.
- R4: The registered fall-through address is always the PC plus 1, for every class.
- R5: For class 1, the target is the PC plus a 20-bit offset. The offset is built as {instr[31], instr[19:12], instr[20], instr[30:21]}, most significant bit first.
- R6: For class 3, the target is the PC plus a 12-bit offset built as {instr[31], instr[7], instr[30:25], instr[11:8]}.
- R7: `rs1_idx` equals instr[19:15] combinationally. For class 2, the target is `base_val` plus instr[31:20].
- R8: For class 0, the target is still computed, using the branch formula of R6.
- R9: While `pipe_en` is low, all three registered outputs keep their values, whatever the other inputs do.
- R10: A synchronous active-high reset clears the class, the target and the fall-through address to 0.
- R11: Every offset is sign-extended from its top bit to 32 bits before the addition, so a negative offset moves the target below the PC or base (modulo 2^32).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| pipe_en | input | 1 | Pipeline enable; the outputs load only when this is high |
| pc | input | 32 | Word-indexed program counter of the fetched instruction |
| instr | input | 32 | Fetched instruction word |
| itype | input | 3 | Decoded instruction-type code |
| base_val | input | 32 | Register value selected by `rs1_idx` |
| rs1_idx | output | 5 | Base register index, instr[19:15] |
| hz_class | output | 2 | Registered class: 0 none, 1 direct jump, 2 indirect jump, 3 branch |
| tgt_addr | output | 32 | Registered taken target |
| seq_addr | output | 32 | Registered fall-through address |

## Verification
The hardest case to reach from the ports is a priority conflict. This happens when the opcode field holds 7'h67 but the type code also says branch or direct jump. Random instruction words almost never produce that opcode, so the stimulus forces the opcode on a share of the random cycles and pairs it with each type code.

The indirect path needs a base value that truly depends on the exported index. The bench therefore models a register file whose contents differ for every index. It drives `base_val` from `rs1_idx`, so a wrong index field gives a wrong sum.

// File: rtl/xfer_classifier.sv
module xfer_classifier #(
  parameter int          XLEN     = 32,
  parameter int          TYPE_W   = 3,
  parameter int          BR_CODE  = 3,
  parameter int          JAL_CODE = 5,
  parameter logic [6:0]  IND_OPC  = 7'h67
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pipe_en,
  input  logic [XLEN-1:0]   pc,
  input  logic [31:0]       instr,
  input  logic [TYPE_W-1:0] itype,
  input  logic [XLEN-1:0]   base_val,
  output logic [4:0]        rs1_idx,
  output logic [1:0]        hz_class,
  output logic [XLEN-1:0]   tgt_addr,
  output logic [XLEN-1:0]   seq_addr
);
  localparam logic [1:0] C_NONE = 2'd0;
  localparam logic [1:0] C_JAL  = 2'd1;
  localparam logic [1:0] C_IND  = 2'd2;
  localparam logic [1:0] C_BR   = 2'd3;

  logic [11:0]     br_off;
  logic [19:0]     jal_off;
  logic [11:0]     ind_off;
  logic [XLEN-1:0] br_sx, jal_sx, ind_sx;
  logic [1:0]      cls_nx;
  logic [XLEN-1:0] tgt_nx;

  assign rs1_idx = instr[19:15];
  assign br_off  = {instr[31], instr[7], instr[30:25], instr[11:8]};
  assign jal_off = {instr[31], instr[19:12], instr[20], instr[30:21]};
  assign ind_off = instr[31:20];
  assign br_sx   = {{(XLEN-12){br_off[11]}}, br_off};
  assign jal_sx  = {{(XLEN-20){jal_off[19]}}, jal_off};
  assign ind_sx  = {{(XLEN-12){ind_off[11]}}, ind_off};

  always_comb begin
    if (itype == TYPE_W'(BR_CODE))        cls_nx = C_BR;
    else if (itype == TYPE_W'(JAL_CODE))  cls_nx = C_JAL;
    else if (instr[6:0] == IND_OPC)       cls_nx = C_IND;
    else                                  cls_nx = C_NONE;
  end

  always_comb begin
    unique case (cls_nx)
      C_JAL:   tgt_nx = pc + jal_sx;
      C_IND:   tgt_nx = base_val + ind_sx;
      default: tgt_nx = pc + br_sx;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hz_class <= C_NONE;
      tgt_addr <= '0;
      seq_addr <= '0;
    end else if (pipe_en) begin
      hz_class <= cls_nx;
      tgt_addr <= tgt_nx;
      seq_addr <= pc + XLEN'(1);
    end
  end

  assert_reset_clear_R10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (hz_class == 2'd0 && tgt_addr == '0 && seq_addr == '0));

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(pipe_en)) |->
      ($stable(hz_class) && $stable(tgt_addr) && $stable(seq_addr)));

  assert_seq_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pipe_en)) |-> seq_addr == $past(pc) + XLEN'(1));

  assert_branch_first_R1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pipe_en) && $past(itype) == TYPE_W'(BR_CODE)) |-> hz_class == 2'd3);

  assert_jal_code_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pipe_en) && $past(itype) == TYPE_W'(JAL_CODE)) |-> hz_class == 2'd1);

  assert_ind_opcode_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pipe_en) && hz_class == 2'd2) |-> $past(instr[6:0]) == IND_OPC);
endmodule

// File: tb/tb_xfer_classifier.sv
module tb_xfer_classifier;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pipe_en = 1'b0;
  logic [31:0] pc = '0;
  logic [31:0] instr = '0;
  logic [2:0]  itype = '0;
  logic [31:0] base_val;
  logic [4:0]  rs1_idx;
  logic [1:0]  hz_class;
  logic [31:0] tgt_addr, seq_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] rf [32];
  assign base_val = rf[rs1_idx];

  always #4 clk = ~clk;

  xfer_classifier dut (
    .clk(clk), .rst(rst), .pipe_en(pipe_en), .pc(pc), .instr(instr),
    .itype(itype), .base_val(base_val), .rs1_idx(rs1_idx),
    .hz_class(hz_class), .tgt_addr(tgt_addr), .seq_addr(seq_addr)
  );

  int    m_cls = 0;
  int    m_tgt = 0;
  int    m_seq = 0;
  string tag_cls = "R10";
  string tag_tgt = "R10";
  string tag_seq = "R10";

  function automatic int sext(int v, int bits);
    if ((v >> (bits - 1)) & 1) return v - (1 << bits);
    return v;
  endfunction

  function automatic int field(logic [31:0] w, int lo, int n);
    int r = 0;
    for (int j = 0; j < n; j++) if (w[lo + j]) r += (1 << j);
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cls <= 0; m_tgt <= 0; m_seq <= 0;
      tag_cls <= "R10"; tag_tgt <= "R10"; tag_seq <= "R10";
    end else if (!pipe_en) begin
      tag_cls <= "R9"; tag_tgt <= "R9"; tag_seq <= "R9";
    end else begin
      int boff, joff, ioff, c;
      boff = field(instr, 8, 4) + (field(instr, 25, 6) << 4)
           + (field(instr, 7, 1) << 10) + (field(instr, 31, 1) << 11);
      joff = field(instr, 21, 10) + (field(instr, 20, 1) << 10)
           + (field(instr, 12, 8) << 11) + (field(instr, 31, 1) << 19);
      ioff = field(instr, 20, 12);
      if (itype == 3) c = 3;
      else if (itype == 5) c = 1;
      else if (field(instr, 0, 7) == 103) c = 2;
      else c = 0;
      m_cls <= c;
      m_seq <= pc + 1;
      tag_seq <= "R4";
      case (c)
        1: begin m_tgt <= pc + sext(joff, 20); tag_tgt <= "R5"; tag_cls <= "R2"; end
        2: begin m_tgt <= rf[field(instr, 15, 5)] + sext(ioff, 12); tag_tgt <= "R7"; tag_cls <= "R3"; end
        3: begin m_tgt <= pc + sext(boff, 12); tag_tgt <= "R6"; tag_cls <= "R1"; end
        default: begin m_tgt <= pc + sext(boff, 12); tag_tgt <= "R8"; tag_cls <= "R3"; end
      endcase
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(tag_cls, {30'd0, hz_class}, m_cls, "hz_class");
    chk(tag_tgt, tgt_addr, m_tgt, "tgt_addr");
    chk(tag_seq, seq_addr, m_seq, "seq_addr");
    chk("R7", {27'd0, rs1_idx}, field(instr, 15, 5), "rs1_idx");
  endtask

  task automatic drive(bit en, int it, logic [31:0] ins, logic [31:0] p);
    @(negedge clk);
    compare_all();
    pipe_en = en; itype = it[2:0]; instr = ins; pc = p;
  endtask

  initial begin
    for (int k = 0; k < 32; k++) rf[k] = 32'h1000_0000 + k * 32'h0101_0111;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    compare_all();
    rst = 1'b0;
    // R1: branch code wins over the indirect opcode
    drive(1, 3, 32'h0000_0067, 32'd100);
    // R2: jump code wins over the indirect opcode
    drive(1, 5, 32'h0020_00E7, 32'd200);
    // R3: indirect opcode with neutral type code; R7 base from rs1
    drive(1, 0, 32'h0053_8067, 32'd300);
    // R11: negative branch offset (all ones -> -1)
    drive(1, 3, 32'hFE00_0F80, 32'd50);
    // R11: negative jump offset
    drive(1, 5, 32'hFFFF_F06F, 32'd10);
    // R11: negative indirect immediate
    drive(1, 2, 32'hFFF2_8067, 32'd7);
    // R8: no transfer still gets branch-style target
    drive(1, 1, 32'h7E00_0F33, 32'hFFFF_FFFF);
    // R9: hold while disabled with changing inputs
    drive(0, 5, 32'hDEAD_BEEF, 32'h1234);
    drive(0, 3, 32'h0000_0067, 32'h9999);
    drive(1, 4, 32'h0000_0013, 32'd0);
    for (int n = 0; n < 400; n++) begin
      logic [31:0] w;
      int sel;
      w = $urandom;
      sel = $urandom_range(0, 9);
      if ($urandom_range(0, 2) == 0) w[6:0] = 7'h67;
      drive($urandom_range(0, 4) != 0, (sel < 3) ? 3 : (sel < 6) ? 5 : sel, w, $urandom);
      if (n == 200) begin
        @(negedge clk);
        compare_all();
        rst = 1'b1;
        @(negedge clk);
        compare_all();
        rst = 1'b0;
      end
    end
    drive(0, 0, 32'h0, 32'h0);
    @(negedge clk);
    compare_all();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule